// File: doc/BRIEF.md
# Cascadable Dual Compare Timer

The block holds two up-counters of HALF_W bits each, a low half and a high half. With the mode input low they run as two independent timers, each advanced by its own count tick. With the mode input high the low half's carry out advances the high half, and the pair acts as one counter of twice the width, compared against the two compare registers joined together. Each half has a compare register, a compare-match flag, an overflow flag, an overflow interrupt enable and a clear-on-match enable. The four enables and four flags live in a single 8-bit control/status register.

Software reaches the control/status register, both counters and both compare registers through a simple bus with address, write strobe, read strobe, write data and combinational read data. A flag can be cleared only by reading it as 1 and then writing 0 to it. Each half raises its interrupt line while its overflow flag and its overflow interrupt enable are both set.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the control/status register reads 0x00, both counters read 0, both compare registers read all ones, and both interrupt outputs are 0.
- R2: With `mode16` low, each counter advances by one on every cycle where its own tick input is 1, and holds otherwise. On a tick that takes a counter from all ones to 0, that half's overflow flag sets. Bit 3 is the low overflow flag and bit 7 is the high overflow flag.
- R3: With `mode16` low, a tick seen while a counter equals its compare register sets that half's compare flag (bit 2 low, bit 6 high). If that half's clear enable is 1 (bit 0 low, bit 4 high), the counter goes to 0 on that tick instead of advancing. If the enable is 0, the counter keeps counting.
- R4: When a match with clear enabled happens on a tick where the counter is all ones, the counter goes to 0 and the overflow flag does not set.
- R5: With `mode16` high, the high counter advances exactly when the low counter wraps, and `tick_hi` has no effect. The low flags still follow the low half alone. The high overflow flag sets when the joined counter wraps from all ones to 0.
- R6: With `mode16` high, a `tick_lo` seen while {high counter, low counter} equals {high compare, low compare} sets the high compare flag. If bit 4 is 1, that tick clears both counters. Bit 0 has no effect in this mode.
- R7: Writing 0 to a flag bit of the control/status register (address 0) clears the flag only if that flag has been read as 1 since it was last set. Writing 0 without that read leaves the flag set. Writing 1 to a flag bit never changes it, and the flag stays armed.
- R8: If a flag is set by hardware in the same cycle as a clearing write, the flag stays set and its armed state is dropped. A later 0 write needs a fresh read before it clears the flag.
- R9: `irq_lo` is 1 exactly when the low overflow flag and bit 1 are both 1. `irq_hi` is 1 exactly when the high overflow flag and bit 5 are both 1.
- R10: The address map is: 0 control/status, 1 low counter, 2 high counter, 3 low compare, 4 high compare. Any other address reads 0. A counter write shows on the next clock, and a tick in the same cycle is dropped for that half.
- R11: Control bits 5, 4, 1 and 0 are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; arms flags read as 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tick_lo | input | 1 | Count enable of the low counter |
| tick_hi | input | 1 | Count enable of the high counter (independent mode only) |
| mode16 | input | 1 | 1 joins the halves into one counter |
| irq_lo | output | 1 | Low overflow interrupt request |
| irq_hi | output | 1 | High overflow interrupt request |

## Verification
The bench builds the timer with HALF_W set to 4. Every compare value of each half can then be swept with and without clear-on-match, and tick counts can be driven past the wrap. In joined mode the whole 256-state range is reached in a few hundred ticks, so matches, low carries and the full wrap all occur in one run. Expected counts and flags come from modular arithmetic and a small step-by-step model of the tick rules. Separate sequences cover the flag-clearing protocol, the set-wins collision, interrupt gating and counter writes.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;

    localparam int REG_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_FLAGS = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CSR    = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4
    } dct_addr_e;

    typedef struct packed {
        logic ovf_hi;
        logic cmf_hi;
        logic ovie_hi;
        logic clr_hi;
        logic ovf_lo;
        logic cmf_lo;
        logic ovie_lo;
        logic clr_lo;
    } dct_csr_t;

    localparam int B_CLR_LO  = 0;
    localparam int B_OVIE_LO = 1;
    localparam int B_CLR_HI  = 4;
    localparam int B_OVIE_HI = 5;

    // Flag index: 0 low match, 1 low overflow, 2 high match, 3 high overflow
    function automatic int flag_pos(input int idx);
        return (idx < 2) ? idx + 2 : idx + 4;
    endfunction

endpackage

// File: rtl/dct_counter.sv
`timescale 1ns/1ps
module dct_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count,
    output logic         wrap
);
    // A wrap needs an increment from all ones that no clear or load overrides
    assign wrap = tick && !clear && !load && (&count);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/dct_flag.sv
`timescale 1ns/1ps
module dct_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_csr_i,
    input  logic wr_csr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_i) begin
            flag_o  <= 1'b1;
            armed_q <= 1'b0;
        end else if (wr_csr_i && !wbit_i && armed_q) begin
            flag_o  <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_csr_i && flag_o) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_cmp_timer.sv
`timescale 1ns/1ps
module dual_cmp_timer
    import dct_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tick_lo,
    input  logic              tick_hi,
    input  logic              mode16,
    output logic              irq_lo,
    output logic              irq_hi
);
    localparam int FULL_W = 2 * HALF_W;

    logic [HALF_W-1:0] cnt_lo_q, cnt_hi_q, cmp_lo_q, cmp_hi_q;
    logic clr_lo_q, ovie_lo_q, clr_hi_q, ovie_hi_q;
    logic csr_wr, csr_rd, ld_lo, ld_hi, ld_cmp_lo, ld_cmp_hi;
    logic tick_eff_lo, tick_eff_hi;
    logic match_lo, match_hi, match_full;
    logic clear_lo, clear_hi, wrap_lo, wrap_hi;
    logic [NUM_FLAGS-1:0] flag_set, flag_q;
    dct_csr_t csr_view;
    logic [REG_W-1:0] csr_bits;

    // Bus decode
    assign csr_wr    = bus_wr && (bus_addr == A_CSR);
    assign csr_rd    = bus_rd && (bus_addr == A_CSR);
    assign ld_lo     = bus_wr && (bus_addr == A_CNT_LO);
    assign ld_hi     = bus_wr && (bus_addr == A_CNT_HI);
    assign ld_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);
    assign ld_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);

    // Count events
    assign tick_eff_lo = tick_lo && !ld_lo;
    assign match_lo    = tick_eff_lo && (cnt_lo_q == cmp_lo_q);
    assign match_full  = tick_eff_lo &&
                         ({cnt_hi_q, cnt_lo_q} == FULL_W'({cmp_hi_q, cmp_lo_q}));
    assign clear_lo    = mode16 ? (match_full && clr_hi_q) : (match_lo && clr_lo_q);

    assign tick_eff_hi = (mode16 ? wrap_lo : tick_hi) && !ld_hi;
    assign match_hi    = mode16 ? match_full : (tick_eff_hi && (cnt_hi_q == cmp_hi_q));
    assign clear_hi    = match_hi && clr_hi_q;

    dct_counter #(.W(HALF_W)) u_cnt_lo (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_lo),
        .load_val (bus_wdata[HALF_W-1:0]),
        .tick     (tick_eff_lo),
        .clear    (clear_lo),
        .count    (cnt_lo_q),
        .wrap     (wrap_lo)
    );

    dct_counter #(.W(HALF_W)) u_cnt_hi (
        .clk      (clk),
        .rst      (rst),
        .load     (ld_hi),
        .load_val (bus_wdata[HALF_W-1:0]),
        .tick     (tick_eff_hi),
        .clear    (clear_hi),
        .count    (cnt_hi_q),
        .wrap     (wrap_hi)
    );

    // Status flags with read-then-write-zero clearing
    assign flag_set = {wrap_hi, match_hi, wrap_lo, match_lo};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam int POS = flag_pos(g);
        dct_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .set_i    (flag_set[g]),
            .rd_csr_i (csr_rd),
            .wr_csr_i (csr_wr),
            .wbit_i   (bus_wdata[POS]),
            .flag_o   (flag_q[g])
        );
    end

    // Control bits and compare registers
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_lo_q  <= 1'b0;
            ovie_lo_q <= 1'b0;
            clr_hi_q  <= 1'b0;
            ovie_hi_q <= 1'b0;
        end else if (csr_wr) begin
            clr_lo_q  <= bus_wdata[B_CLR_LO];
            ovie_lo_q <= bus_wdata[B_OVIE_LO];
            clr_hi_q  <= bus_wdata[B_CLR_HI];
            ovie_hi_q <= bus_wdata[B_OVIE_HI];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_lo_q <= '1;
            cmp_hi_q <= '1;
        end else begin
            if (ld_cmp_lo) cmp_lo_q <= bus_wdata[HALF_W-1:0];
            if (ld_cmp_hi) cmp_hi_q <= bus_wdata[HALF_W-1:0];
        end
    end

    // Register view and read mux
    always_comb begin
        csr_view.ovf_hi  = flag_q[3];
        csr_view.cmf_hi  = flag_q[2];
        csr_view.ovie_hi = ovie_hi_q;
        csr_view.clr_hi  = clr_hi_q;
        csr_view.ovf_lo  = flag_q[1];
        csr_view.cmf_lo  = flag_q[0];
        csr_view.ovie_lo = ovie_lo_q;
        csr_view.clr_lo  = clr_lo_q;
    end
    assign csr_bits = csr_view;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CSR:    bus_rdata = csr_bits;
            A_CNT_LO: bus_rdata[HALF_W-1:0] = cnt_lo_q;
            A_CNT_HI: bus_rdata[HALF_W-1:0] = cnt_hi_q;
            A_CMP_LO: bus_rdata[HALF_W-1:0] = cmp_lo_q;
            A_CMP_HI: bus_rdata[HALF_W-1:0] = cmp_hi_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_lo = csr_view.ovf_lo && csr_view.ovie_lo;
    assign irq_hi = csr_view.ovf_hi && csr_view.ovie_hi;

endmodule

// File: rtl/dct_checker.sv
`timescale 1ns/1ps
module dct_checker
    import dct_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              tick_lo,
    input logic              tick_hi,
    input logic              mode16,
    input logic              irq_lo,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] cnt_hi,
    input logic [HALF_W-1:0] cmp_lo,
    input logic [HALF_W-1:0] cmp_hi,
    input logic [REG_W-1:0]  csr
);
    logic wr_lo, wr_hi;
    assign wr_lo = bus_wr && (bus_addr == 3'd1);
    assign wr_hi = bus_wr && (bus_addr == 3'd2);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (csr == 8'h00 && cnt_lo == '0 && cnt_hi == '0));

    // R2
    hi_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode16 && !tick_hi && !wr_hi) |=> $stable(cnt_hi));

    // R3
    lo_match_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode16 && tick_lo && !wr_lo && cnt_lo == cmp_lo && csr[0]) |=> (cnt_lo == '0));

    // R3
    lo_match_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode16 && tick_lo && !wr_lo && cnt_lo == cmp_lo) |=> csr[2]);

    // R5
    hi_ignores_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode16 && !wr_hi && !(tick_lo && !wr_lo)) |=> $stable(cnt_hi));

    // R6
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode16 && tick_lo && !wr_lo && !wr_hi && cnt_hi == cmp_hi && cnt_lo == cmp_lo && csr[4])
        |=> (cnt_lo == '0 && cnt_hi == '0));

    // R7
    flag_fall_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(csr[2]) |-> $past(bus_wr && bus_addr == 3'd0 && !bus_wdata[2]));

    // R9
    irq_lo_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_lo) |-> csr[1]);

endmodule

bind dual_cmp_timer dct_checker #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tick_lo   (tick_lo),
    .tick_hi   (tick_hi),
    .mode16    (mode16),
    .irq_lo    (irq_lo),
    .cnt_lo    (cnt_lo_q),
    .cnt_hi    (cnt_hi_q),
    .cmp_lo    (cmp_lo_q),
    .cmp_hi    (cmp_hi_q),
    .csr       (csr_bits)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb_top;
    localparam int HALF_W = 4;
    localparam int HMOD   = 1 << HALF_W;
    localparam int FMOD   = HMOD * HMOD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_lo = 1'b0;
    logic       tick_hi = 1'b0;
    logic       mode16 = 1'b0;
    logic       irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_cmp_timer #(.HALF_W(HALF_W)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_lo(tick_lo), .tick_hi(tick_hi),
        .mode16(mode16), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit with_tick);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_lo = with_tick;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; tick_lo = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_lo(input int n);
        if (n > 0) begin
            tick_lo = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            tick_lo = 1'b0;
        end
    endtask

    task automatic run_hi(input int n);
        if (n > 0) begin
            tick_hi = 1'b1;
            repeat (n) @(posedge clk);
            @(negedge clk);
            tick_hi = 1'b0;
        end
    endtask

    task automatic clear_flags();
        logic [7:0] d;
        bus_read(3'd0, d);
        bus_write(3'd0, d & 8'h33, 1'b0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d, c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(3'd0, d); check("R1", "csr", d, 0);
        bus_read(3'd1, d); check("R1", "cnt_lo", d, 0);
        bus_read(3'd2, d); check("R1", "cnt_hi", d, 0);
        bus_read(3'd3, d); check("R1", "cmp_lo", d, HMOD - 1);
        bus_read(3'd4, d); check("R1", "cmp_hi", d, HMOD - 1);
        check("R1", "irq_lo", irq_lo, 0);
        check("R1", "irq_hi", irq_hi, 0);

        // R11 control bits
        bus_write(3'd0, 8'h33, 1'b0);
        bus_read(3'd0, d); check("R11", "ctrl set", d, 8'h33);
        bus_write(3'd0, 8'h00, 1'b0);
        bus_read(3'd0, d); check("R11", "ctrl clear", d, 8'h00);

        // R2 R3 R4 low half sweep, independent mode
        for (int cmp = 0; cmp < HMOD; cmp++) begin
            for (int clr = 0; clr < 2; clr++) begin
                for (int kk = 0; kk < 4; kk++) begin
                    int k, ecnt, ecm, eovf;
                    k = (kk == 0) ? cmp : (kk == 1) ? cmp + 1 : (kk == 2) ? 2 * cmp + 3 : HMOD + 1;
                    bus_write(3'd0, 8'(clr), 1'b0);
                    clear_flags();
                    bus_write(3'd3, 8'(cmp), 1'b0);
                    bus_write(3'd1, 8'h00, 1'b0);
                    bus_write(3'd2, 8'h00, 1'b0);
                    run_lo(k);
                    ecm  = (k >= cmp + 1) ? 1 : 0;
                    ecnt = clr ? (k % (cmp + 1)) : (k % HMOD);
                    eovf = clr ? 0 : ((k >= HMOD) ? 1 : 0);
                    bus_read(3'd1, d); check(clr ? "R3" : "R2", "lo count", d, ecnt);
                    bus_read(3'd0, d);
                    check("R3", "lo match flag", d[2], ecm);
                    check((clr && cmp == HMOD - 1) ? "R4" : "R2", "lo ovf flag", d[3], eovf);
                    bus_read(3'd2, d); check("R2", "hi untouched", d, 0);
                end
            end
        end

        // R2 R3 high half, independent mode
        for (int cmp = 0; cmp < HMOD; cmp += 3) begin
            for (int clr = 0; clr < 2; clr++) begin
                int k, ecnt, eovf;
                k = HMOD + 2;
                bus_write(3'd0, clr ? 8'h10 : 8'h00, 1'b0);
                clear_flags();
                bus_write(3'd4, 8'(cmp), 1'b0);
                bus_write(3'd2, 8'h00, 1'b0);
                bus_write(3'd1, 8'h00, 1'b0);
                run_hi(k);
                ecnt = clr ? (k % (cmp + 1)) : (k % HMOD);
                eovf = clr ? 0 : 1;
                bus_read(3'd2, d); check("R3", "hi count", d, ecnt);
                bus_read(3'd0, d);
                check("R3", "hi match flag", d[6], 1);
                check("R2", "hi ovf flag", d[7], eovf);
                bus_read(3'd1, d); check("R2", "lo untouched", d, 0);
            end
        end

        // R5 R6 joined mode, tick_hi held high to show it is ignored
        mode16 = 1'b1;
        tick_hi = 1'b1;
        for (int hi_i = 0; hi_i < 4; hi_i++) begin
            for (int lo_i = 0; lo_i < 3; lo_i++) begin
                for (int clr = 0; clr < 2; clr++) begin
                    for (int kk = 0; kk < 3; kk++) begin
                        int ch, cl, cc, k, v, hcm, hov, lcm, lov;
                        ch = (hi_i == 0) ? 0 : (hi_i == 1) ? 1 : (hi_i == 2) ? 5 : HMOD - 1;
                        cl = (lo_i == 0) ? 0 : (lo_i == 1) ? 7 : HMOD - 1;
                        cc = ch * HMOD + cl;
                        k  = (kk == 0) ? cc : (kk == 1) ? cc + 1 : FMOD + 44;
                        bus_write(3'd0, clr ? 8'h11 : 8'h01, 1'b0);
                        clear_flags();
                        bus_write(3'd3, 8'(cl), 1'b0);
                        bus_write(3'd4, 8'(ch), 1'b0);
                        bus_write(3'd1, 8'h00, 1'b0);
                        bus_write(3'd2, 8'h00, 1'b0);
                        run_lo(k);
                        v = 0; hcm = 0; hov = 0; lcm = 0; lov = 0;
                        for (int t = 0; t < k; t++) begin
                            if ((v % HMOD) == cl) lcm = 1;
                            if (v == cc) begin
                                hcm = 1;
                                if (clr) begin v = 0; continue; end
                            end
                            if ((v % HMOD) == HMOD - 1) lov = 1;
                            if (v == FMOD - 1) hov = 1;
                            v = (v + 1) % FMOD;
                        end
                        bus_read(3'd1, d); check("R5", "joined lo count", d, v % HMOD);
                        bus_read(3'd2, d); check(clr ? "R6" : "R5", "joined hi count", d, v / HMOD);
                        bus_read(3'd0, d);
                        check("R6", "joined match flag", d[6], hcm);
                        check("R5", "joined hi ovf", d[7], hov);
                        check("R5", "lo match flag joined", d[2], lcm);
                        check("R5", "lo ovf flag joined", d[3], lov);
                    end
                end
            end
        end
        tick_hi = 1'b0;
        mode16 = 1'b0;

        // R7 R9 flag clearing protocol on the low overflow flag
        bus_write(3'd0, 8'h02, 1'b0);
        clear_flags();
        bus_write(3'd3, 8'h05, 1'b0);
        bus_write(3'd1, 8'(HMOD - 1), 1'b0);
        run_lo(1);
        check("R9", "irq_lo with enable", irq_lo, 1);
        check("R9", "irq_hi idle", irq_hi, 0);
        bus_write(3'd0, 8'h02, 1'b0);
        check("R7", "zero write without read keeps flag", irq_lo, 1);
        bus_read(3'd0, d); check("R7", "flag reads 1", d[3], 1);
        bus_write(3'd0, 8'h0A, 1'b0);
        check("R7", "write 1 no effect", irq_lo, 1);
        bus_write(3'd0, 8'h02, 1'b0);
        check("R7", "armed zero write clears", irq_lo, 0);
        bus_read(3'd0, d); check("R7", "flag reads 0", d[3], 0);

        // R9 enable off masks the request
        bus_write(3'd0, 8'h00, 1'b0);
        bus_write(3'd1, 8'(HMOD - 1), 1'b0);
        run_lo(1);
        check("R9", "irq_lo masked", irq_lo, 0);
        bus_write(3'd0, 8'h02, 1'b0);
        check("R9", "irq_lo after enable", irq_lo, 1);
        clear_flags();
        check("R7", "cleared via read and write", irq_lo, 0);

        // R9 high half request
        bus_write(3'd0, 8'h20, 1'b0);
        bus_write(3'd2, 8'(HMOD - 1), 1'b0);
        run_hi(1);
        check("R9", "irq_hi with enable", irq_hi, 1);
        check("R9", "irq_lo off", irq_lo, 0);
        clear_flags();
        check("R9", "irq_hi cleared", irq_hi, 0);

        // R8 set and clear in the same cycle
        bus_write(3'd0, 8'h02, 1'b0);
        bus_write(3'd1, 8'(HMOD - 1), 1'b0);
        run_lo(1);
        bus_write(3'd1, 8'(HMOD - 1), 1'b0);
        bus_read(3'd0, d);
        bus_write(3'd0, 8'h02, 1'b1);
        check("R8", "set wins", irq_lo, 1);
        bus_write(3'd0, 8'h02, 1'b0);
        check("R8", "arm dropped", irq_lo, 1);
        clear_flags();
        check("R8", "fresh read then clear", irq_lo, 0);

        // R10 bus map and counter write timing
        bus_write(3'd1, 8'h05, 1'b1);
        bus_read(3'd1, c); check("R10", "write beats tick", c, 5);
        bus_write(3'd2, 8'h09, 1'b0);
        bus_read(3'd2, c); check("R10", "hi counter write", c, 9);
        bus_write(3'd3, 8'h0C, 1'b0);
        bus_read(3'd3, c); check("R10", "lo compare readback", c, 12);
        bus_write(3'd4, 8'h03, 1'b0);
        bus_read(3'd4, c); check("R10", "hi compare readback", c, 3);
        bus_read(3'd7, c); check("R10", "unmapped reads 0", c, 0);
        bus_read(3'd5, c); check("R10", "unmapped 5 reads 0", c, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule